// File: doc/BRIEF.md
# Receive DC Offset Trim Unit

This unit sits between the decimation filter of a two-channel (I and Q) receive path and the serial output formatter. It removes the DC offset left by the analog front end. Each channel keeps one signed offset word. While the calibrate request is high, the word is forced to zero. The first filter result that arrives after the request drops is captured as the new offset. After that capture, every filter result leaves the block with the stored offset subtracted, and the difference is clamped to the 16-bit signed range.

The offset words are kept through receive sleep. While either sleep input is high, incoming results are ignored. A hold-time monitor counts how long the calibrate request stays high. If the request is released too early, the monitor raises a sticky error flag, but the capture still takes place. The modulator-zero request is passed to an output through one register stage. Nothing else in the block depends on it.

Top module: `rx_dc_trim`

## Requirements
- R1: While `cal_req` is high, both offset words are zero. Any strobed result in that time leaves the block unchanged (`out = in`).
- R2: The first strobed result after `cal_req` falls becomes the new offset, even when idle cycles come before it. The output for that result is 0. Later results do not change the offset until the next calibration.
- R3: A strobed, awake result at a rising edge gives `out_valid = 1` after that edge, with `out = in - offset`. An edge with no strobe, or with the block asleep, gives `out_valid = 0`.
- R4: A difference above 32767 is clamped to 16'h7FFF. A difference below -32768 is clamped to 16'h8000. The result never wraps.
- R5: While `sleep_a` or `sleep_b` is high, strobes are ignored and `out_valid` stays 0. The offsets are kept and are applied again after wake-up.
- R6: `mod_zero_sel` equals `zero_req` from one clock edge earlier.
- R7: If `cal_req` was high at 609 or more rising edges, its fall leaves `short_cal_err` at 0. If it was high at 608 or fewer, its fall sets `short_cal_err`, which then stays at 1 until reset. The capture still happens in both cases.
- R8: Reset clears both offsets, `short_cal_err`, `out_valid` and `mod_zero_sel`.
- R9: The I and Q lanes capture and correct independently. Each lane uses its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Calibrate request |
| zero_req | input | 1 | Modulator-zero request |
| sleep_a | input | 1 | Receive sleep, first input |
| sleep_b | input | 1 | Receive sleep, second input |
| smp_valid | input | 1 | Filter result strobe |
| smp_i | input | 16 | I filter result, two's complement |
| smp_q | input | 16 | Q filter result, two's complement |
| out_valid | output | 1 | Corrected result strobe |
| out_i | output | 16 | Corrected I result |
| out_q | output | 16 | Corrected Q result |
| mod_zero_sel | output | 1 | Registered modulator-zero select |
| short_cal_err | output | 1 | Sticky flag: calibrate pulse too short |

## Verification
The subtraction is checked with a sweep of 256 inputs that runs from -32768 to 32767 in steps of 257. The sweep runs once with zero offsets, which separates a plain pass-through from a wrong subtraction. It runs again with a positive I offset and a negative Q offset, which drives each lane into the opposite clamp and catches swapped lanes and wrap-around. The capture is tried with idle cycles between the calibrate fall and the first strobe, and with several strobes while calibrating, to tell "first result after the fall" apart from any other choice. Hold times of 609 and 608 edges, sleep on each input, and a reset after calibration mark the boundaries.

// File: rtl/rx_dc_trim_pkg.sv
package rx_dc_trim_pkg;

  typedef enum logic {
    LM_RUN   = 1'b0,
    LM_ARMED = 1'b1
  } lane_mode_e;

  // a - b clamped to a w-bit signed range
  function automatic int clamp_sub(input int a, input int b, input int w);
    longint d;
    longint hi;
    longint lo;
    d  = longint'(a) - longint'(b);
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (d > hi) return int'(hi);
    if (d < lo) return int'(lo);
    return int'(d);
  endfunction

endpackage

// File: rtl/rx_dc_trim_hold_mon.sv
module rx_dc_trim_hold_mon #(
  parameter int MIN_HOLD = 608
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_hi,
  output logic cal_fell,
  output logic short_err
);
  localparam int LIMIT = MIN_HOLD + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic          cal_q;
  logic [CW-1:0] hi_cnt;

  assign cal_fell = cal_q & ~cal_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q     <= 1'b0;
      hi_cnt    <= '0;
      short_err <= 1'b0;
    end else begin
      cal_q <= cal_hi;
      if (cal_hi) begin
        if (hi_cnt != CW'(LIMIT)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      if (cal_fell && (hi_cnt < CW'(LIMIT))) short_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_dc_trim_lane.sv
module rx_dc_trim_lane
  import rx_dc_trim_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_hi,
  input  logic                 take,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout,
  output logic signed [DW-1:0] off,
  output logic                 armed
);
  lane_mode_e            mode;
  logic                  capture;
  logic signed [DW-1:0]  eff;
  int                    diff;

  assign armed   = (mode == LM_ARMED);
  assign capture = armed & ~cal_hi & take;

  always_comb begin
    if (cal_hi)       eff = '0;
    else if (capture) eff = din;
    else              eff = off;
    diff = clamp_sub(int'(din), int'(eff), DW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off  <= '0;
      mode <= LM_RUN;
      dout <= '0;
    end else begin
      if (cal_hi) begin
        off  <= '0;
        mode <= LM_ARMED;
      end else if (capture) begin
        off  <= din;
        mode <= LM_RUN;
      end
      if (take) dout <= DW'(diff);
    end
  end
endmodule

// File: rtl/rx_dc_trim.sv
module rx_dc_trim #(
  parameter int DW       = 16,
  parameter int MIN_HOLD = 608
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_req,
  input  logic          zero_req,
  input  logic          sleep_a,
  input  logic          sleep_b,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] smp_q,
  output logic          out_valid,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          mod_zero_sel,
  output logic          short_cal_err
);
  localparam int NCH = 2;

  logic                 awake;
  logic                 take;
  logic                 cal_fell;
  logic signed [DW-1:0] lane_in  [NCH];
  logic signed [DW-1:0] lane_out [NCH];
  logic signed [DW-1:0] lane_off [NCH];
  logic                 lane_arm [NCH];
  logic signed [DW-1:0] off_i, off_q;
  logic                 armed_i, armed_q;

  assign awake      = ~(sleep_a | sleep_b);
  assign take       = smp_valid & awake;
  assign lane_in[0] = smp_i;
  assign lane_in[1] = smp_q;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    rx_dc_trim_lane #(.DW(DW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .cal_hi(cal_req),
      .take  (take),
      .din   (lane_in[c]),
      .dout  (lane_out[c]),
      .off   (lane_off[c]),
      .armed (lane_arm[c])
    );
  end

  assign out_i   = lane_out[0];
  assign out_q   = lane_out[1];
  assign off_i   = lane_off[0];
  assign off_q   = lane_off[1];
  assign armed_i = lane_arm[0];
  assign armed_q = lane_arm[1];

  rx_dc_trim_hold_mon #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_hi   (cal_req),
    .cal_fell (cal_fell),
    .short_err(short_cal_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      mod_zero_sel <= 1'b0;
    end else begin
      out_valid    <= take;
      mod_zero_sel <= zero_req;
    end
  end
endmodule

// File: rtl/rx_dc_trim_chk.sv
module rx_dc_trim_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cal_req,
  input logic          zero_req,
  input logic          sleep_a,
  input logic          sleep_b,
  input logic          smp_valid,
  input logic          out_valid,
  input logic          mod_zero_sel,
  input logic          short_cal_err,
  input logic          cal_fell,
  input logic [DW-1:0] off_i,
  input logic [DW-1:0] off_q,
  input logic          armed_i,
  input logic          armed_q
);
  // R1
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> (off_i == '0 && off_q == '0));
  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_req && !armed_i && !armed_q) |=> ($stable(off_i) && $stable(off_q)));
  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !sleep_a && !sleep_b) |=> out_valid);
  // R5
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_a || sleep_b) && !cal_req) |=> (!out_valid && $stable(off_i) && $stable(off_q)));
  // R6
  mzero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> mod_zero_sel);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_cal_err |=> short_cal_err);
  // R7
  err_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_cal_err && !cal_fell) |=> !short_cal_err);
endmodule

bind rx_dc_trim rx_dc_trim_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cal_req      (cal_req),
  .zero_req     (zero_req),
  .sleep_a      (sleep_a),
  .sleep_b      (sleep_b),
  .smp_valid    (smp_valid),
  .out_valid    (out_valid),
  .mod_zero_sel (mod_zero_sel),
  .short_cal_err(short_cal_err),
  .cal_fell     (cal_fell),
  .off_i        (off_i),
  .off_q        (off_q),
  .armed_i      (armed_i),
  .armed_q      (armed_q)
);

// File: tb/rx_dc_trim_bench.sv
`timescale 1ns/1ps
module rx_dc_trim_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_req = 1'b0, zero_req = 1'b0, sleep_a = 1'b0, sleep_b = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic        out_valid, mod_zero_sel, short_cal_err;
  logic [15:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rx_dc_trim u_rx_dc_trim (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .zero_req(zero_req),
    .sleep_a(sleep_a), .sleep_b(sleep_b), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .mod_zero_sel(mod_zero_sel), .short_cal_err(short_cal_err)
  );

  function automatic int expect_out(int x, int o);
    int d = x - o;
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one strobe; outputs compared one cycle later
  task automatic send(input int xi, input int xq, input int oi, input int oq,
                      input bit asleep, input string tag);
    int ei, eq;
    @(negedge clk);
    smp_valid = 1'b1; smp_i = 16'(xi); smp_q = 16'(xq);
    @(negedge clk);
    smp_valid = 1'b0;
    if (asleep) begin
      check(out_valid == 1'b0, {tag, " valid"}, int'(out_valid), 0);
    end else begin
      ei = expect_out(xi, oi);
      eq = expect_out(xq, oq);
      check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
      check($signed(out_i) == ei, {tag, " I"}, int'($signed(out_i)), ei);
      check($signed(out_q) == eq, {tag, " Q"}, int'($signed(out_q)), eq);
    end
  endtask

  task automatic cal_hold(input int n);
    @(negedge clk);
    cal_req = 1'b1;
    repeat (n) @(negedge clk);
    cal_req = 1'b0;
  endtask

  task automatic sweep(input int oi, input int oq, input string tag);
    for (int k = 0; k < 256; k++) begin
      int x = k * 257 - 32768;
      send(x, -x - 1, oi, oq, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0, "R8 out_valid", int'(out_valid), 0);
    check(short_cal_err == 0, "R8 err", int'(short_cal_err), 0);
    check(mod_zero_sel == 0, "R8 mzero", int'(mod_zero_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0, "R3 idle", int'(out_valid), 0);

    // R8 zero offsets after reset, R3 pass-through sweep
    sweep(0, 0, "R8 R3 zero offset");

    // R1 strobes during calibration pass unchanged
    @(negedge clk); cal_req = 1'b1;
    send(1234, -555, 0, 0, 1'b0, "R1 during cal");
    send(-32768, 32767, 0, 0, 1'b0, "R1 during cal extreme");
    cal_hold(700);
    // R2 idle cycles before first strobe
    repeat (5) @(negedge clk);
    check(short_cal_err == 0, "R7 long hold", int'(short_cal_err), 0);
    send(12288, -20000, 12288, -20000, 1'b0, "R2 capture");
    send(12288 + 7, -20000 - 9, 12288, -20000, 1'b0, "R2 after capture");
    // R4 R9 clamping in opposite directions per lane
    sweep(12288, -20000, "R4 R9 offset sweep");

    // R5 sleep on each input
    @(negedge clk); sleep_a = 1'b1;
    send(100, 100, 0, 0, 1'b1, "R5 sleep_a");
    @(negedge clk); sleep_a = 1'b0; sleep_b = 1'b1;
    send(200, 200, 0, 0, 1'b1, "R5 sleep_b");
    @(negedge clk); sleep_b = 1'b0;
    send(300, 300, 12288, -20000, 1'b0, "R5 offset kept");

    // R6 modulator-zero pass-through
    @(negedge clk); zero_req = 1'b1;
    @(negedge clk);
    check(mod_zero_sel == 1, "R6 rise", int'(mod_zero_sel), 1);
    zero_req = 1'b0;
    @(negedge clk);
    check(mod_zero_sel == 0, "R6 fall", int'(mod_zero_sel), 0);

    // R7 exactly 609 edges: no error
    cal_hold(609);
    @(negedge clk);
    check(short_cal_err == 0, "R7 609 edges", int'(short_cal_err), 0);
    send(-500, 400, -500, 400, 1'b0, "R2 recapture");
    send(0, 0, -500, 400, 1'b0, "R2 recapture apply");

    // R7 608 edges: error, capture still done, sticky
    cal_hold(608);
    @(negedge clk);
    check(short_cal_err == 1, "R7 608 edges", int'(short_cal_err), 1);
    send(77, -88, 77, -88, 1'b0, "R7 capture on short");
    send(1077, 912, 77, -88, 1'b0, "R7 apply after short");
    repeat (20) @(negedge clk);
    check(short_cal_err == 1, "R7 sticky", int'(short_cal_err), 1);

    // R8 reset clears offsets and error
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    check(short_cal_err == 0, "R8 err cleared", int'(short_cal_err), 0);
    send(1077, 912, 0, 0, 1'b0, "R8 offsets cleared");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule